// File: doc/BRIEF.md
# SD/MMC Block Transfer Sequencer

This block runs the data phase of an SD/MMC host controller. Software programs a block shape (bytes per block and a block count) and a mode word (direction, single or multiple blocks, whether the count is used), then starts the transfer. The block steps through the transfer one block at a time. It moves data through an internal block buffer, and software reaches that buffer one 32-bit word at a time through a data port. A ready flag tells software that a whole block can be drained or filled. A completion flag marks the end of the final block.

The serial card lines are not part of this block. They are replaced by a simple card-side model. On a read, the model fills the buffer with one byte per cycle, using a counting pattern. On a write, it drains the buffer one byte per cycle onto a byte output. All status flags are sticky and are cleared by writing ones to them.

Top module: `sd_blkxfer_seq`

## Requirements
- R1: After reset, every status flag is 0, `card_wr_vld` is 0, the shape and mode registers read 0, and no transfer is active.
- R2: Register address 0 holds the block shape: the byte length in the low bits (a multiple of 4, from 4 up to four times `BUF_WORDS`) and the block count in bits 31:16. Address 1 holds the mode: bit 0 sets the direction (1 reads from the card, 0 writes to the card), bit 1 selects multi-block, and bit 2 enables the count. Writing bit 3 as 1 starts a transfer. Address 2 is status and address 3 is the data port.
- R3: In single-block mode exactly one block moves and the count field is ignored. In multi-block mode with the count enabled, the block count sets the number of blocks. In multi-block mode without the count, blocks repeat without end and transfer-complete never sets.
- R4: On a read, the card model stores one byte per cycle. Each byte's value is its running byte number since start, modulo 256. Byte k lands in word k/4 at bit 8*(k mod 4), so words are little-endian. Read-ready (status bit 5) sets at the clock edge that stores the block's last byte, which is the length-th edge after the start edge.
- R5: While a read block is waiting for software, each data-port read returns the next word and advances one word. A data-port read with no word pending returns the last word returned, does not advance, and raises no flag.
- R6: After read-ready, the next block does not begin to fill, and read-ready does not set again, until software has read every word of the current block.
- R7: On a write, write-ready (status bit 4) sets one cycle after start and again after each non-final block. Data-port writes store successive words. After length/4 words, the block emits its bytes on `card_wr_vld`/`card_wr_byte`, one per cycle, lowest byte of each word first. Data-port writes made while the block is not waiting for words are ignored.
- R8: Transfer-complete (status bit 1) sets at the edge that finishes the final block. On a read, that is the edge of its last word read. On a write, it is the edge of its last emitted byte.
- R9: Writing status clears each flag whose bit is 1 and leaves flags whose bit is 0 unchanged. If the hardware sets a flag in the same cycle that software clears it, the flag ends up set.
- R10: A start in multi-block mode with the count enabled and a count of 0 moves no data and sets transfer-complete one cycle after the start.
- R11: While a transfer is active, writes to the shape and mode registers, including a new start, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a data-port read advances the word pointer |
| reg_addr | input | 2 | Register address (0 shape, 1 mode, 2 status, 3 data port) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| rd_ready_o | output | 1 | Read-ready flag |
| wr_ready_o | output | 1 | Write-ready flag |
| xfer_done_o | output | 1 | Transfer-complete flag |
| card_wr_vld | output | 1 | Card-side byte valid during a write block |
| card_wr_byte | output | 8 | Card-side byte towards the card |

## Verification
Software clearing a status flag and the hardware setting that same flag can land in the same edge. The bench provokes this in a multi-block read. It reads the last word of a block, then counts exactly length cycles of refill and writes the read-ready clear bit so that the write lands on the edge that stores the new block's last byte. The flag must read as set afterwards, and the cycle-accurate model in the bench must agree with it on every clock. A second overlap is also exercised: a data-port write arriving in the first drain cycle, while card-side bytes are being emitted. The bench judges it by comparing every emitted byte against the words that were written.

// File: rtl/sdx_pkg.sv
`timescale 1ns/1ps
package sdx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_HOST  = 2'd2,
        ST_DRAIN = 2'd3
    } seq_st_e;

    localparam logic [1:0] A_SHAPE = 2'd0;
    localparam logic [1:0] A_MODE  = 2'd1;
    localparam logic [1:0] A_FLAGS = 2'd2;
    localparam logic [1:0] A_PORT  = 2'd3;

    // bit positions in the status word
    localparam int B_TC   = 1;
    localparam int B_WRDY = 4;
    localparam int B_RRDY = 5;

    // positions in the internal flag vector
    localparam int F_TC   = 0;
    localparam int F_WRDY = 1;
    localparam int F_RRDY = 2;
    localparam int NFLAG  = 3;
endpackage

// File: rtl/sdx_buf.sv
`timescale 1ns/1ps
module sdx_buf #(
    parameter  int WORDS  = 16,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int BIDX_W = WIDX_W + 2
) (
    input  logic              clk,
    input  logic              byte_we,
    input  logic [BIDX_W-1:0] byte_idx,
    input  logic [7:0]        byte_in,
    input  logic              word_we,
    input  logic [WIDX_W-1:0] word_idx,
    input  logic [31:0]       word_in,
    input  logic [WIDX_W-1:0] rd_idx,
    output logic [31:0]       rd_word
);
    logic [31:0] all_w [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_cell
        logic [31:0] cell_q;
        always_ff @(posedge clk) begin
            if (byte_we && (byte_idx[BIDX_W-1:2] == WIDX_W'(g))) begin
                cell_q[8*byte_idx[1:0] +: 8] <= byte_in;
            end else if (word_we && (word_idx == WIDX_W'(g))) begin
                cell_q <= word_in;
            end
        end
        assign all_w[g] = cell_q;
    end

    assign rd_word = all_w[rd_idx];
endmodule

// File: rtl/sdx_flags.sv
`timescale 1ns/1ps
module sdx_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_d, flag_q;

    // a hardware set overrides a software clear in the same cycle
    always_comb begin
        flag_d = (flag_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/sd_blkxfer_seq.sv
`timescale 1ns/1ps
module sd_blkxfer_seq
    import sdx_pkg::*;
#(
    parameter int BUF_WORDS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        rd_ready_o,
    output logic        wr_ready_o,
    output logic        xfer_done_o,
    output logic        card_wr_vld,
    output logic [7:0]  card_wr_byte
);
    localparam int WIDX_W = $clog2(BUF_WORDS);
    localparam int BIDX_W = WIDX_W + 2;
    localparam int LEN_W  = BIDX_W + 1;
    localparam int CNT_W  = 16;

    typedef struct packed {
        seq_st_e           st;
        logic [31:0]       shape;
        logic [2:0]        mode;
        logic [BIDX_W-1:0] bidx;
        logic [WIDX_W-1:0] wptr;
        logic [CNT_W-1:0]  left;
        logic              unb;
        logic [7:0]        pat;
        logic [31:0]       last;
    } seq_t;

    seq_t d, q;

    logic [LEN_W-1:0]  len, words;
    logic              byte_end, word_end, final_blk;
    logic              host_rd, host_wr, fill_we, port_we;
    logic [NFLAG-1:0]  set_v, clr_v, flags;
    logic [31:0]       buf_word, flag_word;
    logic [WIDX_W-1:0] buf_ridx;
    logic              unused_shape_bits;

    assign unused_shape_bits = ^q.shape[15:LEN_W];

    always_comb begin
        d         = q;
        set_v     = '0;
        fill_we   = 1'b0;
        port_we   = 1'b0;
        len       = q.shape[LEN_W-1:0];
        words     = len >> 2;
        byte_end  = (LEN_W'(q.bidx) == len - LEN_W'(1));
        word_end  = (LEN_W'(q.wptr) == words - LEN_W'(1));
        final_blk = !q.unb && (q.left == CNT_W'(1));
        host_rd   = reg_rd && (reg_addr == A_PORT) && (q.st == ST_HOST) && q.mode[0];
        host_wr   = reg_wr && (reg_addr == A_PORT) && (q.st == ST_HOST) && !q.mode[0];

        unique case (q.st)
            ST_IDLE: begin
                if (reg_wr && (reg_addr == A_SHAPE)) d.shape = reg_wdata;
                if (reg_wr && (reg_addr == A_MODE)) begin
                    d.mode = reg_wdata[2:0];
                    if (reg_wdata[3]) begin
                        if (reg_wdata[1] && reg_wdata[2] && (q.shape[31:16] == '0)) begin
                            set_v[F_TC] = 1'b1;
                        end else begin
                            d.unb  = reg_wdata[1] & ~reg_wdata[2];
                            d.left = reg_wdata[1] ? q.shape[31:16] : CNT_W'(1);
                            d.bidx = '0;
                            d.wptr = '0;
                            d.pat  = '0;
                            if (reg_wdata[0]) begin
                                d.st = ST_FILL;
                            end else begin
                                d.st = ST_HOST;
                                set_v[F_WRDY] = 1'b1;
                            end
                        end
                    end
                end
            end
            ST_FILL: begin
                fill_we = 1'b1;
                d.pat   = q.pat + 8'd1;
                d.bidx  = q.bidx + BIDX_W'(1);
                if (byte_end) begin
                    d.bidx = '0;
                    d.wptr = '0;
                    d.st   = ST_HOST;
                    set_v[F_RRDY] = 1'b1;
                end
            end
            ST_HOST: begin
                if (host_rd || host_wr) begin
                    port_we = host_wr;
                    if (host_rd) d.last = buf_word;
                    d.wptr = q.wptr + WIDX_W'(1);
                    if (word_end) begin
                        d.wptr = '0;
                        if (host_wr) begin
                            d.st   = ST_DRAIN;
                            d.bidx = '0;
                        end else begin
                            if (!q.unb) d.left = q.left - CNT_W'(1);
                            if (final_blk) begin
                                d.st = ST_IDLE;
                                set_v[F_TC] = 1'b1;
                            end else begin
                                d.st   = ST_FILL;
                                d.bidx = '0;
                            end
                        end
                    end
                end
            end
            ST_DRAIN: begin
                d.bidx = q.bidx + BIDX_W'(1);
                if (byte_end) begin
                    d.bidx = '0;
                    if (!q.unb) d.left = q.left - CNT_W'(1);
                    if (final_blk) begin
                        d.st = ST_IDLE;
                        set_v[F_TC] = 1'b1;
                    end else begin
                        d.st = ST_HOST;
                        set_v[F_WRDY] = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign clr_v = (reg_wr && (reg_addr == A_FLAGS))
                 ? {reg_wdata[B_RRDY], reg_wdata[B_WRDY], reg_wdata[B_TC]} : '0;

    sdx_flags #(.N(NFLAG)) i_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .flag_o (flags)
    );

    assign buf_ridx = (q.st == ST_DRAIN) ? q.bidx[BIDX_W-1:2] : q.wptr;

    sdx_buf #(.WORDS(BUF_WORDS)) i_buf (
        .clk      (clk),
        .byte_we  (fill_we),
        .byte_idx (q.bidx),
        .byte_in  (q.pat),
        .word_we  (port_we),
        .word_idx (q.wptr),
        .word_in  (reg_wdata),
        .rd_idx   (buf_ridx),
        .rd_word  (buf_word)
    );

    always_comb begin
        flag_word         = '0;
        flag_word[B_TC]   = flags[F_TC];
        flag_word[B_WRDY] = flags[F_WRDY];
        flag_word[B_RRDY] = flags[F_RRDY];
        unique case (reg_addr)
            A_SHAPE: reg_rdata = q.shape;
            A_MODE:  reg_rdata = {29'b0, q.mode};
            A_FLAGS: reg_rdata = flag_word;
            default: reg_rdata = host_rd ? buf_word : q.last;
        endcase
    end

    assign rd_ready_o   = flags[F_RRDY];
    assign wr_ready_o   = flags[F_WRDY];
    assign xfer_done_o  = flags[F_TC];
    assign card_wr_vld  = (q.st == ST_DRAIN);
    assign card_wr_byte = buf_word[8*q.bidx[1:0] +: 8];
endmodule

// File: rtl/sdx_seq_chk.sv
`timescale 1ns/1ps
module sdx_seq_chk #(
    parameter int WIDX_W = 4,
    parameter int LEN_W  = 7
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        st,
    input logic              dir,
    input logic              card_vld,
    input logic              rrdy,
    input logic              rrdy_set,
    input logic              rrdy_clr,
    input logic              wrdy,
    input logic              wrdy_clr,
    input logic              tc,
    input logic [WIDX_W-1:0] wptr,
    input logic [LEN_W-1:0]  words
);
    // R7: card-side bytes only leave during a write transfer
    p_vld_write_only_r7: assert property (@(posedge clk) disable iff (rst)
        card_vld |-> !dir);

    // R8: completion only appears as the sequencer returns to idle
    p_tc_idle_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(tc) |-> (st == 2'd0));

    // R9: a clear without a concurrent set removes the flag
    p_w1c_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (rrdy_clr && !rrdy_set) |=> !rrdy);

    // R9: a set wins over a clear in the same cycle
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        rrdy_set |=> rrdy);

    // R6: read-ready is sticky until software clears it
    p_rrdy_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (rrdy && !rrdy_clr) |=> rrdy);

    // R7: write-ready is sticky until software clears it
    p_wrdy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (wrdy && !wrdy_clr) |=> wrdy);

    // R5: the word pointer stays inside the current block while waiting
    p_ptr_range_r5: assert property (@(posedge clk) disable iff (rst)
        (st == 2'd2) |-> (LEN_W'(wptr) < words));
endmodule

bind sd_blkxfer_seq sdx_seq_chk #(.WIDX_W(WIDX_W), .LEN_W(LEN_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .st       (q.st),
    .dir      (q.mode[0]),
    .card_vld (card_wr_vld),
    .rrdy     (flags[2]),
    .rrdy_set (set_v[2]),
    .rrdy_clr (clr_v[2]),
    .wrdy     (flags[1]),
    .wrdy_clr (clr_v[1]),
    .tc       (flags[0]),
    .wptr     (q.wptr),
    .words    (words)
);

// File: tb/test_sd_blkxfer_seq.sv
`timescale 1ns/1ps
module test_sd_blkxfer_seq;
    logic        clk = 1'b0, rst = 1'b1, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        rd_ready, wr_ready, xfer_done, card_wr_vld;
    logic [7:0]  card_wr_byte;

    int checks = 0, errors = 0, cyc = 0;
    logic [7:0] got_bytes[$];

    always #10 clk = ~clk;

    sd_blkxfer_seq i_sd_blkxfer_seq (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_ready_o(rd_ready),
        .wr_ready_o(wr_ready), .xfer_done_o(xfer_done), .card_wr_vld(card_wr_vld),
        .card_wr_byte(card_wr_byte)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ph, m_idx, m_ptr, m_pat, m_left, m_len;
    bit m_unb, m_dir, m_brr, m_bwr, m_tc;
    logic [31:0] m_blk, m_last;
    logic [2:0]  m_ctrl;
    logic [7:0]  m_mem [0:63];

    function automatic logic [31:0] m_word(input int p);
        return {m_mem[4*p+3], m_mem[4*p+2], m_mem[4*p+1], m_mem[4*p]};
    endfunction

    function automatic logic [31:0] m_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_blk;
            2'd1: return {29'b0, m_ctrl};
            2'd2: return {26'b0, m_brr, m_bwr, 2'b0, m_tc, 1'b0};
            default: return (m_ph == 2 && m_dir) ? m_word(m_ptr) : m_last;
        endcase
    endfunction

    always @(posedge clk) begin
        bit fb, fw, ft, adv, fin;
        logic [2:0] clr;
        fb = 0; fw = 0; ft = 0; adv = 0;
        if (rst) begin
            m_ph = 0; m_blk = 0; m_ctrl = 0; m_brr = 0; m_bwr = 0; m_tc = 0;
            m_last = 0; m_idx = 0; m_ptr = 0; m_pat = 0; m_left = 0; m_unb = 0; m_dir = 0;
            m_len = 0;
        end else begin
            fin = !m_unb && (m_left == 1);
            case (m_ph)
                0: begin
                    if (reg_wr && reg_addr == 2'd0) m_blk = reg_wdata;
                    if (reg_wr && reg_addr == 2'd1) begin
                        m_ctrl = reg_wdata[2:0];
                        if (reg_wdata[3]) begin
                            if (reg_wdata[1] && reg_wdata[2] && m_blk[31:16] == 0) ft = 1;
                            else begin
                                m_unb  = reg_wdata[1] && !reg_wdata[2];
                                m_left = reg_wdata[1] ? int'(m_blk[31:16]) : 1;
                                m_dir  = reg_wdata[0];
                                m_len  = int'(m_blk[6:0]);
                                m_idx = 0; m_ptr = 0; m_pat = 0;
                                if (m_dir) m_ph = 1;
                                else begin m_ph = 2; fw = 1; end
                            end
                        end
                    end
                end
                1: begin
                    m_mem[m_idx] = m_pat[7:0];
                    m_pat++;
                    if (m_idx == m_len - 1) begin m_idx = 0; m_ptr = 0; m_ph = 2; fb = 1; end
                    else m_idx++;
                end
                2: begin
                    if (m_dir && reg_rd && reg_addr == 2'd3) begin
                        m_last = m_word(m_ptr); adv = 1;
                    end else if (!m_dir && reg_wr && reg_addr == 2'd3) begin
                        for (int b = 0; b < 4; b++) m_mem[4*m_ptr+b] = reg_wdata[8*b +: 8];
                        adv = 1;
                    end
                    if (adv) begin
                        if (m_ptr == m_len/4 - 1) begin
                            m_ptr = 0;
                            if (!m_dir) begin m_ph = 3; m_idx = 0; end
                            else begin
                                if (!m_unb) m_left--;
                                if (fin) begin m_ph = 0; ft = 1; end
                                else begin m_ph = 1; m_idx = 0; end
                            end
                        end else m_ptr++;
                    end
                end
                default: begin
                    if (m_idx == m_len - 1) begin
                        m_idx = 0;
                        if (!m_unb) m_left--;
                        if (fin) begin m_ph = 0; ft = 1; end
                        else begin m_ph = 2; fw = 1; end
                    end else m_idx++;
                end
            endcase
            clr = (reg_wr && reg_addr == 2'd2) ? {reg_wdata[5], reg_wdata[4], reg_wdata[1]} : 3'b0;
            m_brr = (m_brr && !clr[2]) || fb;
            m_bwr = (m_bwr && !clr[1]) || fw;
            m_tc  = (m_tc  && !clr[0]) || ft;
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R4", rd_ready, m_brr, "read-ready vs model");
            check("R7", wr_ready, m_bwr, "write-ready vs model");
            check("R8", xfer_done, m_tc, "transfer-complete vs model");
            check("R7", card_wr_vld, (m_ph == 3), "card byte valid vs model");
            if (m_ph == 3) check("R7", card_wr_byte, m_mem[m_idx], "card byte vs model");
            if (card_wr_vld) got_bytes.push_back(card_wr_byte);
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R1 watchdog: actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v, input string req);
        reg_rd = 1'b1; reg_addr = a;
        #2;
        v = reg_rdata;
        check(req, v, m_rd(a), "register read vs model");
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [31:0] exp_word(input int b);
        return {8'(b+3), 8'(b+2), 8'(b+1), 8'(b)};
    endfunction

    initial begin
        logic [31:0] v;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1: reset state
        check("R1", {rd_ready, wr_ready, xfer_done, card_wr_vld}, 0, "flags after reset");
        rd(2'd2, v, "R1"); check("R1", v, 0, "status after reset");
        rd(2'd1, v, "R1"); check("R1", v, 0, "mode after reset");

        // single read, count enabled but single mode: one block (R3), length 16
        wr(2'd0, 32'h0000_0010);
        rd(2'd0, v, "R2"); check("R2", v, 32'h10, "shape readback");
        wr(2'd1, 32'hD);
        idle(18);
        check("R4", rd_ready, 1, "read-ready after fill");
        wr(2'd2, 32'h20);
        for (int i = 0; i < 4; i++) begin
            rd(2'd3, v, "R5");
            check("R4", v, exp_word(4*i), "read word pattern");
        end
        rd(2'd3, v, "R5"); check("R5", v, 32'h0F0E0D0C, "read with no word pending");
        check("R8", xfer_done, 1, "complete after last word");
        idle(20);
        check("R3", rd_ready, 0, "single mode moves one block");
        wr(2'd2, 32'h0); check("R9", xfer_done, 1, "zero write keeps flag");
        wr(2'd2, 32'h2); check("R9", xfer_done, 0, "one clears flag");

        // multi read, three blocks of 8 bytes
        wr(2'd0, (32'd3 << 16) | 32'd8);
        wr(2'd1, 32'hF);
        idle(10);
        check("R4", rd_ready, 1, "first block ready");
        wr(2'd2, 32'h20);
        idle(20);
        check("R6", rd_ready, 0, "no refill before words are read");
        rd(2'd3, v, "R5"); check("R6", v, exp_word(0), "block 1 word 0");
        rd(2'd3, v, "R5"); check("R6", v, exp_word(4), "block 1 word 1");
        idle(7);
        wr(2'd2, 32'h20); // lands on the edge that sets read-ready
        check("R9", rd_ready, 1, "set beats clear");
        wr(2'd2, 32'h20);
        rd(2'd3, v, "R5"); check("R4", v, exp_word(8), "block 2 word 0");
        rd(2'd3, v, "R5"); check("R4", v, exp_word(12), "block 2 word 1");
        check("R8", xfer_done, 0, "not complete before final block");
        idle(10);
        rd(2'd3, v, "R5"); check("R4", v, exp_word(16), "block 3 word 0");
        rd(2'd3, v, "R5"); check("R4", v, exp_word(20), "block 3 word 1");
        check("R8", xfer_done, 1, "complete after third block");
        wr(2'd2, 32'h32);
        rd(2'd2, v, "R9"); check("R9", v, 0, "all flags cleared");

        // single write, 16 bytes
        wr(2'd0, 32'h10);
        wr(2'd1, 32'h8);
        check("R7", wr_ready, 1, "write-ready after start");
        wr(2'd2, 32'h10);
        got_bytes.delete();
        for (int i = 0; i < 4; i++) wr(2'd3, exp_word(8'h40 + 4*i));
        wr(2'd3, 32'hDEADBEEF); // ignored: block is draining
        idle(20);
        check("R7", got_bytes.size(), 16, "byte count emitted");
        for (int j = 0; j < 16 && j < got_bytes.size(); j++)
            check("R7", got_bytes[j], 8'h40 + j, "emitted byte order");
        check("R8", xfer_done, 1, "write complete");
        check("R3", wr_ready, 0, "no second write block");
        wr(2'd2, 32'h2);

        // R10: multi with count enabled and zero count
        wr(2'd0, 32'h8);
        wr(2'd1, 32'hF);
        check("R10", xfer_done, 1, "zero count completes at once");
        idle(12);
        check("R10", rd_ready, 0, "zero count moves no data");
        wr(2'd2, 32'h2);

        // unbounded multi write, with ignored register writes while busy
        wr(2'd0, (32'd1 << 16) | 32'd8);
        wr(2'd1, 32'hA);
        for (int blk = 0; blk < 3; blk++) begin
            check("R7", wr_ready, 1, "write-ready per block");
            wr(2'd2, 32'h10);
            wr(2'd3, 32'h11 * (blk + 1));
            wr(2'd3, 32'h2200 * (blk + 1));
            if (blk == 1) begin
                wr(2'd1, 32'h9);
                wr(2'd0, 32'h4);
            end
            idle(12);
            check("R3", xfer_done, 0, "unbounded never completes");
        end
        rd(2'd1, v, "R11"); check("R11", v, 32'h2, "mode write ignored while busy");
        rd(2'd0, v, "R11"); check("R11", v, (32'd1 << 16) | 32'd8, "shape write ignored while busy");
        check("R11", rd_ready, 0, "busy start did not begin a read");

        summary();
        $finish;
    end
endmodule